// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block puts three W-bit parallel ports (A, B and C) and a configuration register behind a small W-bit register bus. A two-bit address picks the target. An access happens only when chip select is high together with a read or write strobe. Each pin group is modelled as three separate vectors: the incoming pin value, the value to drive, and a per-bit output enable. No tri-state pads are modelled.

A configuration write sets the direction of port A, port B and each half of port C. It can also put port A into one of two strobed handshake modes. In those modes some port C lines stop being general-purpose pins and become data-ready, acknowledge, strobe, buffer-full and interrupt-request lines. A control write with the top bit clear does not change the configuration. Instead it sets or clears one port C output bit, so software can toggle a single line without first reading the port.

Read data is registered. It appears on the cycle after the read strobe and holds until the next read.

Top module: `par_port_top`

## Requirements
- R1: After synchronous reset, all output enables are 0 (every port is an input), all output latches are 0, rdata is 0 and the interrupt line pc_out[3] is 0.
- R2: The address selects the target as 00 = port A, 01 = port B, 10 = port C, 11 = control. A write with cs low, or with cs high and wr low, changes no latch.
- R3: A control write with bit 7 = 1 is a configuration word. Bit 0 makes port A an input (1) or an output (0). Bit 1 does the same for port B, bit 2 for C[3:0] and bit 3 for C[7:4]. Bits 5:4 select the port A mode: 00 basic, 01 strobed output, 10 strobed input, 11 basic. A read of the control address returns 1, then 0, then the six stored bits (bits 7 to 0).
- R4: A configuration write clears all three output latches and all handshake flags (data-ready, buffer-full, interrupt).
- R5: A read returns the output latch on bits that are outputs and the pin value on bits that are inputs. rdata changes on the clock edge that samples the read and holds while no read is made.
- R6: A control write with bit 7 = 0 sets port C latch bit wdata[3:1] to wdata[0]. All other port C bits are unchanged.
- R7: In strobed output mode, port A drives all pins and pc_in[6] is an input. A write to port A drives data-ready pc_out[7] to 1 and the interrupt line pc_out[3] to 0.
- R8: In strobed output mode, a rising edge on acknowledge pc_in[6] clears pc_out[7] and sets pc_out[3]. pc_out[3] stays high until the next write to port A.
- R9: In strobed input mode, port A is an input and pc_in[4] is a strobe input. A rising strobe edge captures pa_in and sets buffer-full pc_out[5] and the interrupt line pc_out[3]. Reads of port A return the captured byte even if the pins later change.
- R10: In strobed input mode, a read of port A clears pc_out[5] and pc_out[3].
- R11: In either strobed mode, a read of port C returns the handshake flags in their bit positions, the handshake input pin in its bit position, and the other bits as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe (has priority over rd) |
| addr | input | 2 | Target select |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data |
| pa_in | input | W | Port A pin input |
| pa_out | output | W | Port A drive value |
| pa_oe | output | W | Port A output enable per bit |
| pb_in | input | W | Port B pin input |
| pb_out | output | W | Port B drive value |
| pb_oe | output | W | Port B output enable per bit |
| pc_in | input | W | Port C pin input, including strobe and acknowledge |
| pc_out | output | W | Port C drive value, including handshake flags |
| pc_oe | output | W | Port C output enable per bit |

## Verification
The bench checks the following corner cases and the failure each one catches:
- Mixed nibble directions on port C, read back as a combination of latch bits and pin bits. A design that muxes the whole port would return all-latch or all-pin data.
- A single-bit set followed by a single-bit clear on port C. A design that decodes the wrong field or disturbs neighbouring bits would show wrong bits on pc_out.
- In output mode, the interrupt line is checked after the acknowledge pulse has fallen, so a level-sensitive or self-clearing interrupt would show as 0.
- In input mode, port A is read after the pins have changed. A design without a capture latch would return the new pin value.
- A read of port C is made before the read of port A. A design that clears the flags on the wrong read would lose them.

// File: rtl/par_port_pkg.sv
`timescale 1ns/1ps
package par_port_pkg;

  typedef enum logic [1:0] {
    SEL_A   = 2'b00,
    SEL_B   = 2'b01,
    SEL_C   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    AM_BASIC  = 2'b00,
    AM_OUT_HS = 2'b01,
    AM_IN_HS  = 2'b10,
    AM_RSVD   = 2'b11
  } amode_e;

  typedef struct packed {
    amode_e amode;
    logic   c_hi_in;
    logic   c_lo_in;
    logic   b_in;
    logic   a_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = cfg_t'(6'b00_1111);

  // port C bit roles while port A runs a strobed mode
  localparam int unsigned HS_IRQ_BIT = 3;
  localparam int unsigned HS_STB_BIT = 4;
  localparam int unsigned HS_IBF_BIT = 5;
  localparam int unsigned HS_ACK_BIT = 6;
  localparam int unsigned HS_OBF_BIT = 7;

endpackage

// File: rtl/par_port_decode.sv
`timescale 1ns/1ps
module par_port_decode #(
  parameter int AW = 2
) (
  input  logic                cs,
  input  logic                rd,
  input  logic                wr,
  input  logic [AW-1:0]       addr,
  output logic [(1<<AW)-1:0]  wr_sel,
  output logic [(1<<AW)-1:0]  rd_sel
);
  always_comb begin
    wr_sel = '0;
    rd_sel = '0;
    if (cs && wr)      wr_sel[addr] = 1'b1;
    else if (cs && rd) rd_sel[addr] = 1'b1;
  end
endmodule

// File: rtl/par_port_latch.sv
`timescale 1ns/1ps
module par_port_latch #(
  parameter int W    = 8,
  parameter int IDXW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            we,
  input  logic [W-1:0]    wdata,
  input  logic            bit_we,
  input  logic [IDXW-1:0] bit_idx,
  input  logic            bit_val,
  output logic [W-1:0]    q
);
  always_ff @(posedge clk) begin
    if (rst || clr)  q <= '0;
    else if (we)     q <= wdata;
    else if (bit_we) q[bit_idx] <= bit_val;
  end
endmodule

// File: rtl/par_port_hshake.sv
`timescale 1ns/1ps
module par_port_hshake
  import par_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  amode_e       mode,
  input  logic         clr,
  input  logic         wr_a,
  input  logic         rd_a,
  input  logic         stb_in,
  input  logic         ack_in,
  input  logic [W-1:0] pa_in,
  output logic         obf,
  output logic         ibf,
  output logic         irq,
  output logic [W-1:0] in_lat
);
  logic stb_q, ack_q;
  logic stb_rise, ack_rise;

  assign stb_rise = stb_in & ~stb_q;
  assign ack_rise = ack_in & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      stb_q <= stb_in;
      ack_q <= ack_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      obf    <= 1'b0;
      ibf    <= 1'b0;
      irq    <= 1'b0;
      in_lat <= '0;
    end else begin
      case (mode)
        AM_OUT_HS: begin
          if (wr_a) begin
            obf <= 1'b1;
            irq <= 1'b0;
          end else if (ack_rise) begin
            obf <= 1'b0;
            irq <= 1'b1;
          end
        end
        AM_IN_HS: begin
          if (stb_rise) begin
            in_lat <= pa_in;
            ibf    <= 1'b1;
            irq    <= 1'b1;
          end else if (rd_a) begin
            ibf <= 1'b0;
            irq <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/par_port_top.sv
`timescale 1ns/1ps
module par_port_top
  import par_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cs,
  input  logic         rd,
  input  logic         wr,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [W-1:0] pa_in,
  output logic [W-1:0] pa_out,
  output logic [W-1:0] pa_oe,
  input  logic [W-1:0] pb_in,
  output logic [W-1:0] pb_out,
  output logic [W-1:0] pb_oe,
  input  logic [W-1:0] pc_in,
  output logic [W-1:0] pc_out,
  output logic [W-1:0] pc_oe
);
  localparam int HALF = W / 2;
  localparam int IDXW = $clog2(W);
  localparam int NSEL = 4;

  logic [NSEL-1:0] wr_sel, rd_sel;
  cfg_t            cfg_q;
  amode_e          amode_w;
  logic            mode_wr, bsr_wr;
  logic [W-1:0]    ab_q [2];
  logic [W-1:0]    c_lat;
  logic            obf, ibf, irq;
  logic [W-1:0]    in_lat;
  logic [W-1:0]    pa_oe_c, pb_oe_c, pc_oe_c, pc_drv;
  logic [W-1:0]    a_view, b_view, c_view, ctl_view, rd_val;

  par_port_decode #(.AW(2)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  assign mode_wr = wr_sel[SEL_CTL] &  wdata[W-1];
  assign bsr_wr  = wr_sel[SEL_CTL] & ~wdata[W-1];

  always_ff @(posedge clk) begin
    if (rst)          cfg_q <= CFG_RESET;
    else if (mode_wr) cfg_q <= cfg_t'(wdata[5:0]);
  end
  assign amode_w = cfg_q.amode;

  for (genvar gi = 0; gi < 2; gi++) begin : g_ab
    par_port_latch #(.W(W)) u_lat (
      .clk(clk), .rst(rst), .clr(mode_wr), .we(wr_sel[gi]), .wdata(wdata),
      .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .q(ab_q[gi])
    );
  end

  par_port_latch #(.W(W)) u_clat (
    .clk(clk), .rst(rst), .clr(mode_wr), .we(wr_sel[SEL_C]), .wdata(wdata),
    .bit_we(bsr_wr), .bit_idx(wdata[IDXW:1]), .bit_val(wdata[0]), .q(c_lat)
  );

  par_port_hshake #(.W(W)) u_hs (
    .clk(clk), .rst(rst), .mode(amode_w), .clr(mode_wr),
    .wr_a(wr_sel[SEL_A]), .rd_a(rd_sel[SEL_A]),
    .stb_in(pc_in[HS_STB_BIT]), .ack_in(pc_in[HS_ACK_BIT]), .pa_in(pa_in),
    .obf(obf), .ibf(ibf), .irq(irq), .in_lat(in_lat)
  );

  always_comb begin
    pb_oe_c = {W{~cfg_q.b_in}};
    pc_oe_c = {{(W-HALF){~cfg_q.c_hi_in}}, {HALF{~cfg_q.c_lo_in}}};
    pc_drv  = c_lat;
    case (amode_w)
      AM_OUT_HS: begin
        pa_oe_c             = '1;
        pc_oe_c[HS_OBF_BIT] = 1'b1;
        pc_oe_c[HS_IRQ_BIT] = 1'b1;
        pc_oe_c[HS_ACK_BIT] = 1'b0;
        pc_drv[HS_OBF_BIT]  = obf;
        pc_drv[HS_IRQ_BIT]  = irq;
      end
      AM_IN_HS: begin
        pa_oe_c             = '0;
        pc_oe_c[HS_IBF_BIT] = 1'b1;
        pc_oe_c[HS_IRQ_BIT] = 1'b1;
        pc_oe_c[HS_STB_BIT] = 1'b0;
        pc_drv[HS_IBF_BIT]  = ibf;
        pc_drv[HS_IRQ_BIT]  = irq;
      end
      default: pa_oe_c = {W{~cfg_q.a_in}};
    endcase
  end

  assign pa_out = ab_q[0];
  assign pb_out = ab_q[1];
  assign pc_out = pc_drv;
  assign pa_oe  = pa_oe_c;
  assign pb_oe  = pb_oe_c;
  assign pc_oe  = pc_oe_c;

  always_comb begin
    a_view   = (amode_w == AM_IN_HS) ? in_lat
                                     : ((ab_q[0] & pa_oe_c) | (pa_in & ~pa_oe_c));
    b_view   = (ab_q[1] & pb_oe_c) | (pb_in & ~pb_oe_c);
    c_view   = (pc_drv & pc_oe_c) | (pc_in & ~pc_oe_c);
    ctl_view = {1'b1, {(W-7){1'b0}}, cfg_q};
    if (rd_sel[SEL_A])      rd_val = a_view;
    else if (rd_sel[SEL_B]) rd_val = b_view;
    else if (rd_sel[SEL_C]) rd_val = c_view;
    else                    rd_val = ctl_view;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (|rd_sel) rdata <= rd_val;
  end
endmodule

// File: rtl/par_port_chk.sv
`timescale 1ns/1ps
module par_port_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         cs,
  input logic         rd,
  input logic         wr,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] rdata,
  input logic [W-1:0] pa_out,
  input logic [W-1:0] pb_out,
  input logic [W-1:0] pa_oe,
  input logic [W-1:0] pb_oe,
  input logic [W-1:0] pc_oe,
  input logic [W-1:0] pc_in,
  input logic [W-1:0] pc_out,
  input logic [W-1:0] c_lat,
  input logic [1:0]   amode
);
  localparam int IDXW = $clog2(W);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && rdata == '0 && !pc_out[3]));

  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd) |=> $stable(rdata));

  p_mode_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'b11 && wdata[W-1]) |=> (pa_out == '0 && pb_out == '0 && c_lat == '0));

  p_bit_setreset_r6: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == 2'b11 && !wdata[W-1]) |=> (c_lat[$past(wdata[IDXW:1])] == $past(wdata[0])));

  p_ready_on_write_r7: assert property (@(posedge clk) disable iff (rst)
    (amode == 2'b01 && cs && wr && addr == 2'b00) |=> (pc_out[7] && !pc_out[3]));

  p_ack_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (amode == 2'b01 && $rose(pc_in[6]) && !(cs && wr)) |=> (pc_out[3] && !pc_out[7]));

  p_strobe_full_r9: assert property (@(posedge clk) disable iff (rst)
    (amode == 2'b10 && $rose(pc_in[4]) && !(cs && wr && addr == 2'b11)) |=> (pc_out[5] && pc_out[3]));
endmodule

bind par_port_top par_port_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
  .rdata(rdata), .pa_out(pa_out), .pb_out(pb_out), .pa_oe(pa_oe), .pb_oe(pb_oe),
  .pc_oe(pc_oe), .pc_in(pc_in), .pc_out(pc_out), .c_lat(c_lat), .amode(amode_w)
);

// File: tb/par_port_top_test.sv
`timescale 1ns/1ps
module par_port_top_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [W-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [W-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  par_port_top #(.W(W)) uut (
    .clk(clk), .rst(rst), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    check("R1 pc_out", pc_out, 8'h00);
  endtask

  task automatic t_basic;
    logic [W-1:0] v;
    bus_wr(2'b11, 8'h80);
    check("R3 all out pa_oe", pa_oe, 8'hFF);
    check("R3 all out pc_oe", pc_oe, 8'hFF);
    bus_wr(2'b00, 8'h5A);
    bus_wr(2'b01, 8'hC3);
    bus_wr(2'b10, 8'h96);
    check("R2 port A", pa_out, 8'h5A);
    check("R2 port B", pb_out, 8'hC3);
    check("R2 port C", pc_out, 8'h96);
    bus_rd(2'b01, v);
    check("R5 read B latch", v, 8'hC3);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = 2'b00; wdata = 8'hFF;
    @(negedge clk);
    wr = 1'b0;
    check("R2 cs low ignored", pa_out, 8'h5A);
    @(negedge clk);
    cs = 1'b1; wr = 1'b0; addr = 2'b00; wdata = 8'hFF;
    @(negedge clk);
    cs = 1'b0;
    check("R2 no strobe ignored", pa_out, 8'h5A);
    check("R5 rdata holds", rdata, 8'hC3);
  endtask

  task automatic t_dir;
    logic [W-1:0] v;
    bus_wr(2'b11, 8'h8A);
    check("R4 A cleared", pa_out, 8'h00);
    check("R4 C cleared", pc_out, 8'h00);
    check("R3 pa_oe", pa_oe, 8'hFF);
    check("R3 pb_oe", pb_oe, 8'h00);
    check("R3 pc_oe nibbles", pc_oe, 8'h0F);
    bus_rd(2'b11, v);
    check("R3 control readback", v, 8'h8A);
    pb_in = 8'h3C;
    pc_in = 8'hA5;
    bus_rd(2'b01, v);
    check("R5 read B pins", v, 8'h3C);
    bus_wr(2'b10, 8'h06);
    bus_rd(2'b10, v);
    check("R5 read C mixed", v, 8'hA6);
    pc_in = 8'h00;
  endtask

  task automatic t_bitset;
    bus_wr(2'b11, 8'h80);
    bus_wr(2'b11, 8'h0B);
    check("R6 set bit5", pc_out, 8'h20);
    bus_wr(2'b11, 8'h01);
    check("R6 set bit0", pc_out, 8'h21);
    bus_wr(2'b11, 8'h0A);
    check("R6 clear bit5", pc_out, 8'h01);
  endtask

  task automatic t_hs_out;
    logic [W-1:0] v;
    bus_wr(2'b11, 8'h91);
    check("R7 pa_oe forced", pa_oe, 8'hFF);
    check("R7 pc_oe roles", pc_oe, 8'hBF);
    check("R4 ready clear", pc_out, 8'h00);
    bus_wr(2'b00, 8'h77);
    check("R7 data", pa_out, 8'h77);
    check("R7 ready high", pc_out & 8'h88, 8'h80);
    @(negedge clk);
    pc_in[6] = 1'b1;
    @(negedge clk);
    check("R8 ack response", pc_out & 8'h88, 8'h08);
    pc_in[6] = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 irq held", pc_out & 8'h88, 8'h08);
    bus_rd(2'b10, v);
    check("R11 read C out mode", v, 8'h08);
    bus_wr(2'b00, 8'h12);
    check("R8 write clears irq", pc_out & 8'h88, 8'h80);
    bus_wr(2'b11, 8'h90);
    check("R4 mode clears ready", pc_out & 8'h88, 8'h00);
  endtask

  task automatic t_hs_in;
    logic [W-1:0] v;
    bus_wr(2'b11, 8'hA0);
    check("R9 pa_oe input", pa_oe, 8'h00);
    check("R9 pc_oe roles", pc_oe, 8'hEF);
    pa_in = 8'h3E;
    @(negedge clk);
    pc_in[4] = 1'b1;
    @(negedge clk);
    check("R9 full and irq", pc_out & 8'h28, 8'h28);
    pa_in = 8'h99;
    bus_rd(2'b10, v);
    check("R11 read C in mode", v, 8'h38);
    check("R10 C read keeps flags", pc_out & 8'h28, 8'h28);
    bus_rd(2'b00, v);
    check("R9 captured byte", v, 8'h3E);
    check("R10 A read clears", pc_out & 8'h28, 8'h00);
    pc_in[4] = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_dir();
    t_bitset();
    t_hs_out();
    t_hs_in();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule